// File: doc/BRIEF.md
# Port Expander Bring-Up Write Controller

This block brings an 8-bit port expander on a two-wire I2C bus into a known state after reset, with no help from software. Once reset is released it performs two write transactions. The first loads the expander's pin-direction register. The second loads its output-level register. The block then releases both bus lines and stays idle until the next reset.

Both bus lines are open-drain. The block never drives a line high. For each line it only decides whether to pull it low (an output enable that the pad turns into a low drive) or to release it to the pull-up. The SCL timing comes from a counter on the system clock. That counter splits each SCL period into four equal quarters.

The controller releases SDA in the ninth bit of every byte and samples it there as the acknowledge. A missing acknowledge sets a sticky error flag. The transaction in progress is then closed with STOP and the rest of the sequence is abandoned. A one-cycle done pulse marks the end of the sequence.

Top module: `pexp_bringup`

## Requirements
- R1: While `rst` is high at a clock edge, `scl_oe`, `sda_oe`, `done` and `err` are all 0 after that edge. After `rst` falls, the whole sequence starts again from its first START, even when the reset cut a transaction short.
- R2: Time runs in quarters of QTR = CLK_HZ/(4*SCL_HZ) clocks, with the first quarter starting at the first clock after reset. In every bit slot, `scl_oe` is 1 (SCL low) during the first two quarters and 0 (SCL released) during the last two.
- R3: A transaction opens with a START slot. SCL stays released for all four quarters. SDA is released for the first two quarters and pulled low (`sda_oe`=1) for the last two, so SDA falls while SCL is high.
- R4: In the first quarter of a bit slot, SDA keeps the level it had at the end of the previous slot. It changes only at the start of the second quarter, in the middle of SCL low.
- R5: Bytes go out MSB first. From the second quarter to the end of the slot, `sda_oe` is the inverse of the bit, so a 0 bit pulls SDA low. The bytes are E4h (address 72h with write bit 0), 03h, DIR_VAL (default 0Fh) in the first transaction, and E4h, 01h, OUT_VAL (default AAh) in the second.
- R6: The ninth slot of each byte releases SDA from its second quarter to its end. The line level is sampled on the clock edge that ends the third quarter, while SCL is high. Low there is an acknowledge.
- R7: After the third acknowledge, a STOP slot follows. It has SCL low for two quarters, SDA pulled low from the second quarter, and SDA released in the fourth quarter while SCL is high. After the first transaction's STOP, the second START follows at once.
- R8: A high level at an acknowledge sample sets `err` from the first cycle of that slot's fourth quarter. `err` holds until reset. The next slot is STOP, and no further transaction starts.
- R9: `done` is 1 for exactly one clock, in the first cycle after the final STOP, whether the sequence completed or was aborted by R8. From then on, both lines stay released until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-cycle pulse when the sequence has ended |
| err | output | 1 | Sticky flag: an acknowledge slot saw SDA high |

## Verification
The hardest situations to reach are a missing acknowledge at a chosen byte and a reset in the middle of a transaction. Each of these needs the bus-side response to line up with one specific quarter out of hundreds. The bench models the target as a passive agent that follows its own quarter schedule. For each run, it is told which acknowledge slot (first transaction's address or data byte, or second transaction's data byte) to leave high. A separate run raises reset part way through the first transaction, then checks the released lines and the clean restart.

// File: rtl/pexp_bringup.sv
module pexp_bringup #(
  parameter int         CLK_HZ  = 50_000_000,
  parameter int         SCL_HZ  = 100_000,
  parameter logic [6:0] ADDR7   = 7'h72,
  parameter logic [7:0] DIR_REG = 8'h03,
  parameter logic [7:0] OUT_REG = 8'h01,
  parameter logic [7:0] DIR_VAL = 8'h0F,
  parameter logic [7:0] OUT_VAL = 8'hAA
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_i,
  output logic scl_oe,
  output logic sda_oe,
  output logic done,
  output logic err
);
  localparam int QTR = CLK_HZ / (4 * SCL_HZ);
  localparam int QW  = $clog2(QTR + 1);

  typedef enum logic [1:0] {ST_START, ST_BIT, ST_STOP, ST_FIN} st_t;

  st_t         st;
  logic [QW-1:0] qc;
  logic [1:0]  ph;
  logic [3:0]  bitc;
  logic [1:0]  bsel;
  logic        txn, hold;
  logic [7:0]  cur;
  logic [2:0]  bidx;
  logic        tick, bit_drv;

  assign tick    = (qc == QW'(QTR - 1));
  assign bidx    = 3'(4'd7 - bitc);
  assign bit_drv = (bitc < 4'd8) && !cur[bidx];

  always_comb
    case (bsel)
      2'd0:    cur = {ADDR7, 1'b0};
      2'd1:    cur = txn ? OUT_REG : DIR_REG;
      default: cur = txn ? OUT_VAL : DIR_VAL;
    endcase

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      ST_START: sda_oe = ph[1];
      ST_BIT: begin
        scl_oe = !ph[1];
        sda_oe = (ph == 2'd0) ? hold : bit_drv;
      end
      ST_STOP: begin
        scl_oe = !ph[1];
        sda_oe = (ph == 2'd0) ? hold : (ph != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_START;
      qc   <= '0;
      ph   <= '0;
      bitc <= '0;
      bsel <= '0;
      txn  <= 1'b0;
      hold <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != ST_FIN) begin
        qc <= tick ? '0 : qc + 1'b1;
        if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd2 && st == ST_BIT && bitc == 4'd8 && sda_i)
            err <= 1'b1;
          if (ph == 2'd3) begin
            hold <= sda_oe;
            case (st)
              ST_START: begin
                st   <= ST_BIT;
                bitc <= '0;
                bsel <= '0;
              end
              ST_BIT:
                if (bitc == 4'd8) begin
                  if (err || bsel == 2'd2) st <= ST_STOP;
                  else begin
                    bsel <= bsel + 2'd1;
                    bitc <= '0;
                  end
                end else bitc <= bitc + 4'd1;
              ST_STOP:
                if (!txn && !err) begin
                  txn <= 1'b1;
                  st  <= ST_START;
                end else begin
                  st   <= ST_FIN;
                  done <= 1'b1;
                end
              default: ;
            endcase
          end
        end
      end
    end
  end

  a_r2_scl_on_quarter: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_oe) |-> $past(tick));

  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && !$stable(sda_oe)) |-> (st == ST_START || st == ST_STOP));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(err) |-> err);

  a_r8_no_start_after_err: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START) |-> !err);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(st) == ST_STOP);
endmodule

// File: tb/pexp_bringup_bench.sv
module pexp_bringup_bench;
  localparam int QTR = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pull = 1'b0;
  logic scl_oe, sda_oe, done, err;
  wire  sda_i = !(sda_oe | pull);

  always #2 clk = !clk;

  pexp_bringup #(.CLK_HZ(12_000_000), .SCL_HZ(1_000_000)) u_pexp_bringup (
    .clk(clk), .rst(rst), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .err(err));

  int vec = 0, bad = 0;
  bit finished = 0;
  bit    e_scl[$], e_sda[$], e_pull[$];
  string e_tag[$];
  int    err_q, done_q;

  function automatic void push(bit s, bit d, bit p, string t);
    e_scl.push_back(s); e_sda.push_back(d); e_pull.push_back(p); e_tag.push_back(t);
  endfunction

  function automatic void build(int nack_at);
    bit hold, abort;
    logic [7:0] bytes [6];
    bytes[0] = 8'hE4; bytes[1] = 8'h03; bytes[2] = 8'h0F;   // R5 first transaction
    bytes[3] = 8'hE4; bytes[4] = 8'h01; bytes[5] = 8'hAA;   // R5 second transaction
    e_scl.delete(); e_sda.delete(); e_pull.delete(); e_tag.delete();
    err_q = -1; abort = 0; hold = 0;
    for (int t = 0; t < 2 && !abort; t++) begin
      push(0, 0, 0, "R3"); push(0, 0, 0, "R3"); push(0, 1, 0, "R3"); push(0, 1, 0, "R3");
      hold = 1;
      for (int b = 0; b < 3 && !abort; b++) begin
        for (int i = 7; i >= 0; i--) begin
          bit v = !bytes[t*3+b][i];
          push(1, hold, 0, "R4"); push(1, v, 0, "R5"); push(0, v, 0, "R2"); push(0, v, 0, "R2");
          hold = v;
        end
        begin
          bit a = (t*3 + b) != nack_at;
          push(1, hold, 0, "R6"); push(1, 0, a, "R6"); push(0, 0, a, "R6"); push(0, 0, a, "R6");
          hold = 0;
          if (!a) begin abort = 1; err_q = e_scl.size() - 1; end   // R8
        end
      end
      push(1, hold, 0, "R7"); push(1, 1, 0, "R7"); push(0, 1, 0, "R7"); push(0, 0, 0, "R7");
    end
    done_q = e_scl.size();   // R9
  endfunction

  task automatic chk(logic act, logic exp, string tag, string what, int p);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, what, p, act, exp);
    end
  endtask

  task automatic run(int nack_at, int cut_at);
    build(nack_at);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(scl_oe, 1'b0, "R1", "scl_oe in reset", -1);
      chk(sda_oe, 1'b0, "R1", "sda_oe in reset", -1);
      chk(done,   1'b0, "R1", "done in reset", -1);
      chk(err,    1'b0, "R1", "err in reset", -1);
    end
    rst = 1'b0;
    for (int p = 0; ; p++) begin
      int k = p / QTR;
      if (cut_at >= 0 && p == cut_at) break;
      if (k > e_scl.size() + 3) break;
      pull = (k < e_scl.size()) ? e_pull[k] : 1'b0;
      if (k < e_scl.size()) begin
        chk(scl_oe, e_scl[k], e_tag[k], "scl_oe", p);
        chk(sda_oe, e_sda[k], e_tag[k], "sda_oe", p);
      end else begin
        chk(scl_oe, 1'b0, "R9", "scl_oe idle", p);
        chk(sda_oe, 1'b0, "R9", "sda_oe idle", p);
      end
      chk(err,  (err_q >= 0 && k >= err_q) ? 1'b1 : 1'b0, "R8", "err", p);
      chk(done, (p == done_q * QTR) ? 1'b1 : 1'b0, "R9", "done", p);
      @(negedge clk);
    end
    pull = 1'b0;
  endtask

  initial begin
    run(-1, -1);    // full sequence, all acknowledged
    run(0, -1);     // R8 missing acknowledge on first address byte
    run(2, -1);     // R8 missing acknowledge on first data byte
    run(5, -1);     // R8 missing acknowledge on last data byte
    run(-1, 150);   // R1 reset cuts the first transaction
    run(-1, -1);    // R1 clean restart after the cut
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    end
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    end
    $finish;
  end
endmodule